// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block watches up to eight peripheral request lines and records one pending flag for each line that rises. It gives a processor a single request output and an acknowledge input.

A small register window is read and written over a simple address/data port. One register holds the enable bits for the sources. The other register returns a vector value: the low byte of the table address of the most urgent pending source that is enabled. Writing that vector register with any data discards every pending request at once.

A vector value of zero only means that nothing is pending. Each source owns a table slot of `VEC_STEP` bytes, starting one slot above zero. When the processor acknowledges, the source that the vector currently names leaves the pending set. All other flags stay as they are.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the vector register reads 00h, the enable register reads 00h (every source disabled), and `cpu_irq` is low.
- R2: A low-to-high transition on `src_i[n]` sets pending flag n at the next clock edge. A level held high sets the flag again only after it has dropped and risen again.
- R3: With `VEC_STEP`=4, a read of the vector register at `VEC_ADDR` (E2h) returns 4·(n+1), where n is the lowest-numbered source that is pending and enabled. Source 0 has the highest priority. With sources 4 and 5 both pending, the read returns 14h.
- R4: When no enabled source is pending, the vector register reads 00h.
- R5: The enable register at `MASK_ADDR` (E0h) is written and read back on bits [N_SRC-1:0]. A 1 in bit n enables source n. Flags of disabled sources still latch, but they are hidden from the vector and from `cpu_irq` until their enable bit is set.
- R6: A write of any data value to `VEC_ADDR` clears every pending flag, including the flags of disabled sources.
- R7: A rising edge that arrives in the same cycle as a clear-all write, or as an acknowledge of its own flag, leaves that flag set.
- R8: An acknowledge pulse on `cpu_ack` clears only the flag that the vector register names in that cycle. An acknowledge while nothing enabled is pending changes nothing.
- R9: Reads have no side effect. Repeated reads of either register return the same value while the inputs stay quiet.
- R10: `cpu_irq` is high exactly when at least one enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_SRC | Peripheral request lines (rising edge posts a request) |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DATA_W | Write data |
| cpu_ack | input | 1 | Processor acknowledge, one cycle per serviced request |
| bus_rdata | output | DATA_W | Combinational read data of the addressed register |
| cpu_irq | output | 1 | Request to the processor |

## Verification
The bench checks every possible pending pattern against several enable masks, so an encoder that picks the wrong priority or the wrong slot spacing shows up as a wrong vector value. For all 256 patterns with every source enabled, it drains the pending set one acknowledge at a time. A design that clears more than the winner, or clears the wrong flag, then skips or repeats vectors. Flags that latch while their source is disabled must appear once the source is enabled, so a design that drops masked requests loses them. A rising edge that coincides with a clear-all write must survive it, so a design that gives the clear priority reads zero where a vector is expected.

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl #(
  parameter int N_SRC = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int VEC_STEP = 4,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 8'hE2,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              cpu_ack,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_irq
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] src_q, pend, en, rise, active, win_oh, drop;
  logic [IDX_W-1:0] win_idx;
  logic             hit;
  logic [DATA_W-1:0] vec;

  assign rise   = src_i & ~src_q;
  assign active = pend & en;
  assign cpu_irq = |active;

  always_comb begin
    hit = 1'b0;
    win_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (active[i]) begin
        hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

  assign win_oh = hit ? (N_SRC'(1) << win_idx) : '0;
  assign vec    = hit ? DATA_W'((int'(win_idx) + 1) * VEC_STEP) : '0;

  wire wr_vec  = bus_wr && (bus_addr == VEC_ADDR);
  wire wr_mask = bus_wr && (bus_addr == MASK_ADDR);

  assign drop = wr_vec ? '1 : (cpu_ack ? win_oh : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      pend  <= '0;
      en    <= '0;
    end else begin
      src_q <= src_i;
      pend  <= (pend & ~drop) | rise;
      if (wr_mask) en <= bus_wdata[N_SRC-1:0];
    end
  end

  always_comb begin
    if (bus_addr == VEC_ADDR)       bus_rdata = vec;
    else if (bus_addr == MASK_ADDR) bus_rdata = DATA_W'(en);
    else                            bus_rdata = '0;
  end
endmodule

module irq_vector_ctrl_chk #(
  parameter int N_SRC = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int VEC_STEP = 4,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 8'hE2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  src_i,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              cpu_ack,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              cpu_irq,
  input logic [N_SRC-1:0]  pend,
  input logic [N_SRC-1:0]  en
);
  logic [N_SRC-1:0] src_d;
  always_ff @(posedge clk) begin
    if (!rst_n) src_d <= '0;
    else        src_d <= src_i;
  end
  wire [N_SRC-1:0] rise_c = src_i & ~src_d;
  wire wr_v = bus_wr && (bus_addr == VEC_ADDR);

  p_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_c) |=> ((pend & $past(rise_c)) == $past(rise_c)));

  p_idle_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == VEC_ADDR) |-> ((bus_rdata == '0) == !cpu_irq));

  p_vec_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == VEC_ADDR && cpu_irq) |->
      ((int'(bus_rdata) % VEC_STEP == 0) && (int'(bus_rdata) <= N_SRC * VEC_STEP)));

  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_v && rise_c == '0) |=> (pend == '0));

  p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !wr_v && cpu_irq && rise_c == '0) |=>
      ($countones(pend) + 1 == $countones($past(pend))));

  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & en) == '0) |-> !cpu_irq);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .VEC_STEP(VEC_STEP), .VEC_ADDR(VEC_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .cpu_ack(cpu_ack), .bus_rdata(bus_rdata),
  .cpu_irq(cpu_irq), .pend(pend), .en(en)
);

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
  localparam logic [7:0] VA = 8'hE2;
  localparam logic [7:0] MA = 8'hE0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] src_i = '0, bus_addr = VA, bus_wdata = '0;
  logic bus_wr = 1'b0, cpu_ack = 1'b0;
  logic [7:0] bus_rdata;
  logic cpu_irq;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .cpu_ack(cpu_ack),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  function automatic logic [7:0] exp_vec(input logic [7:0] act);
    logic [7:0] r = 8'h00;
    for (int i = 7; i >= 0; i--) if (act[i]) r = 8'((i + 1) * 4);
    return r;
  endfunction

  function automatic logic [7:0] low_bit(input logic [7:0] v);
    return v & (~v + 8'd1);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_wr = 1'b0; #1; d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; step(); bus_wr = 1'b0; bus_addr = VA;
  endtask

  task automatic post(input logic [7:0] p);
    src_i = p; step(); src_i = '0; step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] masks [4] = '{8'hFF, 8'h00, 8'hA5, 8'h3C};
    repeat (3) step();
    rst_n = 1'b1; step();

    rd(VA, d); chk("R1 vector after reset", d, 8'h00);
    rd(MA, d); chk("R1 mask after reset", d, 8'h00);
    chk("R1 irq after reset", {7'd0, cpu_irq}, 8'h00);

    for (int mi = 0; mi < 4; mi++) begin
      wr(MA, masks[mi]);
      for (int p = 0; p < 256; p++) begin
        wr(VA, 8'h00);
        post(8'(p));
        rd(VA, d); chk("R3 R4 sweep vector", d, exp_vec(8'(p) & masks[mi]));
        chk("R10 sweep irq", {7'd0, cpu_irq}, {7'd0, |(8'(p) & masks[mi])});
      end
    end

    wr(MA, 8'hFF);
    for (int p = 1; p < 256; p++) begin
      logic [7:0] left = 8'(p);
      wr(VA, 8'h00);
      post(left);
      while (left != 0) begin
        rd(VA, d); chk("R8 drain vector", d, exp_vec(left));
        cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
        left = left & ~low_bit(left);
      end
      rd(VA, d); chk("R8 drained", d, 8'h00);
    end

    wr(VA, 8'h00);
    post(8'h30);
    rd(VA, d); chk("R3 sources 4 and 5", d, 8'h14);

    wr(VA, 8'h5A);
    rd(VA, d); chk("R6 clear with 5Ah", d, 8'h00);
    chk("R6 irq after clear", {7'd0, cpu_irq}, 8'h00);

    wr(MA, 8'h00);
    post(8'h08);
    rd(VA, d); chk("R5 masked hidden", d, 8'h00);
    chk("R5 masked irq", {7'd0, cpu_irq}, 8'h00);
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
    wr(MA, 8'h08);
    rd(MA, d); chk("R5 mask readback", d, 8'h08);
    rd(VA, d); chk("R5 latched while masked, R8 idle ack", d, 8'h10);
    wr(MA, 8'h00);
    wr(VA, 8'hFF);
    wr(MA, 8'hFF);
    rd(VA, d); chk("R6 clears masked flags", d, 8'h00);

    src_i = 8'h01; step();
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
    repeat (3) step();
    rd(VA, d); chk("R2 held level no re-post", d, 8'h00);
    src_i = 8'h00; step(); src_i = 8'h01; step(); src_i = 8'h00;
    rd(VA, d); chk("R2 new edge posts", d, 8'h04);

    wr(VA, 8'h00);
    bus_addr = VA; bus_wdata = 8'h77; bus_wr = 1'b1; src_i = 8'h04;
    step(); bus_wr = 1'b0; src_i = 8'h00;
    rd(VA, d); chk("R7 edge beats clear", d, 8'h0C);

    src_i = 8'h04; step(); src_i = 8'h00; step();
    cpu_ack = 1'b1; src_i = 8'h04; step(); cpu_ack = 1'b0; src_i = 8'h00;
    rd(VA, d); chk("R7 edge beats ack", d, 8'h0C);

    post(8'h40);
    for (int k = 0; k < 5; k++) begin
      rd(VA, d); chk("R9 repeated vector read", d, 8'h0C);
      rd(MA, d); chk("R9 repeated mask read", d, 8'hFF);
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule